// File: doc/BRIEF.md
# Quadrature-Phased Fetch/Execute Sequencer

This block runs an instruction fetch and an instruction execute side by side. It divides the core clock into four non-overlapping phase slots, Q1 to Q4, and one instruction cycle lasts all four slots. A program-counter increment strobe comes out in Q1. The 16-bit word on the fetch bus is captured at the end of Q4. That captured word moves into the instruction register at the end of the following Q1, so while it executes, the next word is already being fetched. During execution the operand read strobe fires in Q2 and the destination write strobe fires in Q4.

The sequencer can replace a word with a forced no-operation. It does this when the execute side reports a taken branch, when it reports a skip, when the pipeline is still empty after reset, and when a stray second word appears. Some first-word opcodes are listed as two-word instructions. After one of these executes, the next word must carry 1111 in its top nibble, and its low 12 bits are then handed to execute as a literal. Words are assumed to arrive already assembled from memory, with the low byte taken from the even address.

Top module: `fetch_exec_seq`

## Requirements
- R1: The one-hot phase output `q_phase` cycles Q1→Q2→Q3→Q4→Q1, with bit 0 standing for Q1 and bit 3 for Q4. It is in Q1 during the first cycle after reset.
- R2: `pc_inc` is high during Q1 and low in every other phase.
- R3: A word on `fetch_word` during a Q4 cycle appears on `ir` from the next Q2 and stays there for four cycles.
- R4: `rd_strobe` is high in Q2 and `wr_strobe` is high in Q4 of an executing instruction. Both stay low while `forced_nop` is 1.
- R5: If `branch_taken` is high during Q4, the word captured in that Q4 executes as a forced NOP: `ir` = 0x0000 and `forced_nop` = 1.
- R6: A first word whose top byte matches a two-word entry (default entries: top nibble 0xC, top byte 0xEC or 0xED, top byte 0xEF) executes normally and arms a pending flag. If the next word has top nibble 0xF, it executes with `lit_valid` = 1 and `lit_data` = its bits 11:0 for the whole instruction cycle.
- R7: A word with top nibble 0xF that does not directly follow an armed first word executes as a forced NOP.
- R8: If `skip_req` is high during Q4, the word captured then executes as a forced NOP, and any pending two-word state is dropped.
- R9: Reset is synchronous and active high. It sets `ir` = 0, `forced_nop` = 1 and `lit_valid` = 0. The first instruction cycle after reset executes a NOP.
- R10: An armed first word followed by a word whose top nibble is not 0xF executes that word normally and drops the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one phase slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 16 | Word on the fetch bus, sampled in Q4 |
| branch_taken | input | 1 | Execute reports a PC change, sampled in Q4 |
| skip_req | input | 1 | Execute requests a skip of the next word, sampled in Q4 |
| q_phase | output | 4 | One-hot phase slots, bit 0 = Q1 |
| pc_inc | output | 1 | Program-counter increment strobe |
| ir | output | 16 | Instruction register |
| forced_nop | output | 1 | Current instruction is a forced no-operation |
| lit_valid | output | 1 | Second-word literal is valid |
| lit_data | output | 12 | Second-word literal |
| rd_strobe | output | 1 | Operand read strobe |
| wr_strobe | output | 1 | Destination write strobe |

## Verification
Two things can happen at the same Q4 edge: the word for a two-word instruction is captured, and a flush request (branch or skip) arrives. The bench makes this happen by asserting `skip_req`, and in another case both flush inputs together, exactly when the second word of an armed instruction, or the word right after it, is on the fetch bus. In both cases the flush must win. The word must become a NOP with no literal, and the pending flag must not carry over, so a later 0xF-prefixed word must also turn into a NOP.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

    localparam int WORD_W   = 16;
    localparam int LIT_W    = 12;
    localparam int PREFIX_W = WORD_W - LIT_W;
    localparam int OPC_W    = 8;
    localparam int NUM_PH   = 4;

    localparam logic [PREFIX_W-1:0] SECOND_PREFIX = '1;
    localparam logic [WORD_W-1:0]   NOP_WORD      = '0;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] ir;
        logic              forced_nop;
        logic              lit_valid;
        logic [LIT_W-1:0]  lit;
    } exec_word_t;

    localparam exec_word_t EXEC_NOP = '{ir: NOP_WORD, forced_nop: 1'b1,
                                        lit_valid: 1'b0, lit: '0};

    function automatic phase_e next_phase(input phase_e p);
        unique case (p)
            PH_Q1:   return PH_Q2;
            PH_Q2:   return PH_Q3;
            PH_Q3:   return PH_Q4;
            default: return PH_Q1;
        endcase
    endfunction

    function automatic logic is_second(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: PREFIX_W] == SECOND_PREFIX;
    endfunction

endpackage

// File: rtl/fes_phase_gen.sv
module fes_phase_gen
    import pipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output phase_e            ph,
    output logic [NUM_PH-1:0] q_onehot
);

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_Q1;
        else     ph <= next_phase(ph);
    end

    for (genvar i = 0; i < NUM_PH; i++) begin : g_slot
        assign q_onehot[i] = (ph == phase_e'(i));
    end

endmodule

// File: rtl/fes_fetch_latch.sv
module fes_fetch_latch
    import pipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              branch_taken,
    input  logic              skip_req,
    output logic [WORD_W-1:0] held_word,
    output logic              kill
);

    // kill starts set so the empty pipeline's first slot executes a NOP
    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= NOP_WORD;
            kill      <= 1'b1;
        end else if (capture) begin
            held_word <= fetch_word;
            kill      <= branch_taken | skip_req;
        end
    end

endmodule

// File: rtl/fes_exec_stage.sv
module fes_exec_stage
    import pipe_pkg::*;
#(
    parameter int                   N_DW     = 3,
    parameter logic [N_DW*OPC_W-1:0] DW_MATCH = {8'hC0, 8'hEC, 8'hEF},
    parameter logic [N_DW*OPC_W-1:0] DW_MASK  = {8'hF0, 8'hFE, 8'hFF}
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] held_word,
    input  logic              kill,
    output exec_word_t        xw
);

    logic            pending;
    logic [N_DW-1:0] hit;
    logic            first_word;
    exec_word_t      xw_next;
    logic            pending_next;

    for (genvar i = 0; i < N_DW; i++) begin : g_dw
        assign hit[i] = ((held_word[WORD_W-1 -: OPC_W] ^ DW_MATCH[i*OPC_W +: OPC_W])
                         & DW_MASK[i*OPC_W +: OPC_W]) == '0;
    end
    assign first_word = |hit;

    always_comb begin
        xw_next      = EXEC_NOP;
        pending_next = 1'b0;
        if (!kill) begin
            if (is_second(held_word)) begin
                if (pending) begin
                    xw_next.ir         = held_word;
                    xw_next.forced_nop = 1'b0;
                    xw_next.lit_valid  = 1'b1;
                    xw_next.lit        = held_word[LIT_W-1:0];
                end
            end else begin
                xw_next.ir         = held_word;
                xw_next.forced_nop = 1'b0;
                pending_next       = first_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xw      <= EXEC_NOP;
            pending <= 1'b0;
        end else if (load) begin
            xw      <= xw_next;
            pending <= pending_next;
        end
    end

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
    import pipe_pkg::*;
#(
    parameter int                   N_DW     = 3,
    parameter logic [N_DW*OPC_W-1:0] DW_MATCH = {8'hC0, 8'hEC, 8'hEF},
    parameter logic [N_DW*OPC_W-1:0] DW_MASK  = {8'hF0, 8'hFE, 8'hFF}
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       fetch_word,
    input  logic              branch_taken,
    input  logic              skip_req,
    output logic [3:0]        q_phase,
    output logic              pc_inc,
    output logic [15:0]       ir,
    output logic              forced_nop,
    output logic              lit_valid,
    output logic [11:0]       lit_data,
    output logic              rd_strobe,
    output logic              wr_strobe
);

    phase_e            ph;
    logic [WORD_W-1:0] held_word;
    logic              kill;
    exec_word_t        xw;

    fes_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .q_onehot (q_phase)
    );

    fes_fetch_latch u_fetch (
        .clk          (clk),
        .rst          (rst),
        .capture      (ph == PH_Q4),
        .fetch_word   (fetch_word),
        .branch_taken (branch_taken),
        .skip_req     (skip_req),
        .held_word    (held_word),
        .kill         (kill)
    );

    fes_exec_stage #(
        .N_DW     (N_DW),
        .DW_MATCH (DW_MATCH),
        .DW_MASK  (DW_MASK)
    ) u_exec (
        .clk       (clk),
        .rst       (rst),
        .load      (ph == PH_Q1),
        .held_word (held_word),
        .kill      (kill),
        .xw        (xw)
    );

    assign pc_inc     = (ph == PH_Q1);
    assign ir         = xw.ir;
    assign forced_nop = xw.forced_nop;
    assign lit_valid  = xw.lit_valid;
    assign lit_data   = xw.lit;
    assign rd_strobe  = (ph == PH_Q2) && !xw.forced_nop;
    assign wr_strobe  = (ph == PH_Q4) && !xw.forced_nop;

endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic        clk,
    input logic        rst,
    input logic        branch_taken,
    input logic        skip_req,
    input logic [3:0]  q_phase,
    input logic        pc_inc,
    input logic [15:0] ir,
    input logic        forced_nop,
    input logic        lit_valid,
    input logic        rd_strobe,
    input logic        wr_strobe
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(q_phase) == 1); // R1
    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        q_phase[0] |=> q_phase[1]); // R1
    AST_PCINC_Q1_ONLY: assert property (@(posedge clk) disable iff (rst)
        pc_inc |-> q_phase[0]); // R2
    AST_IR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !q_phase[1] |-> $stable(ir)); // R3
    AST_NOP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        forced_nop |-> (!rd_strobe && !wr_strobe)); // R4
    AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (rst)
        (q_phase[3] && (branch_taken || skip_req)) |-> ##2 forced_nop); // R5
    AST_NOP_IR_ZERO: assert property (@(posedge clk) disable iff (rst)
        forced_nop |-> (ir == 16'h0000)); // R5
    AST_LIT_PREFIX: assert property (@(posedge clk) disable iff (rst)
        lit_valid |-> (ir[15:12] == 4'hF && !forced_nop)); // R6

endmodule

bind fetch_exec_seq fes_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .branch_taken (branch_taken),
    .skip_req     (skip_req),
    .q_phase      (q_phase),
    .pc_inc       (pc_inc),
    .ir           (ir),
    .forced_nop   (forced_nop),
    .lit_valid    (lit_valid),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe)
);

// File: tb/tb_fetch_exec_seq.sv
`timescale 1ns/1ps
module tb_fetch_exec_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] fetch_word;
    logic        branch_taken;
    logic        skip_req;
    logic [3:0]  q_phase;
    logic        pc_inc;
    logic [15:0] ir;
    logic        forced_nop;
    logic        lit_valid;
    logic [11:0] lit_data;
    logic        rd_strobe;
    logic        wr_strobe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fetch_exec_seq dut (
        .clk (clk), .rst (rst), .fetch_word (fetch_word),
        .branch_taken (branch_taken), .skip_req (skip_req),
        .q_phase (q_phase), .pc_inc (pc_inc), .ir (ir),
        .forced_nop (forced_nop), .lit_valid (lit_valid),
        .lit_data (lit_data), .rd_strobe (rd_strobe), .wr_strobe (wr_strobe)
    );

    // {word, branch, skip, exp_ir, exp_nop, exp_litv, exp_lit}
    localparam int NV = 19;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0F55, 1'b0, 1'b0, 16'h0F55, 1'b0, 1'b0, 12'h000}, // R3 plain
        {16'h6E81, 1'b0, 1'b0, 16'h6E81, 1'b0, 1'b0, 12'h000}, // R3
        {16'hEF03, 1'b0, 1'b0, 16'hEF03, 1'b0, 1'b0, 12'h000}, // R6 arm
        {16'hF000, 1'b0, 1'b0, 16'hF000, 1'b0, 1'b1, 12'h000}, // R6 literal
        {16'h1234, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 12'h000}, // R5 flush
        {16'hF456, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 12'h000}, // R7 orphan
        {16'hC123, 1'b0, 1'b0, 16'hC123, 1'b0, 1'b0, 12'h000}, // R6 arm
        {16'hF456, 1'b0, 1'b0, 16'hF456, 1'b0, 1'b1, 12'h456}, // R6
        {16'hC111, 1'b0, 1'b0, 16'hC111, 1'b0, 1'b0, 12'h000}, // R8 arm
        {16'hF222, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 12'h000}, // R8 skip
        {16'hF333, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 12'h000}, // R8 pending dropped
        {16'hEC10, 1'b0, 1'b0, 16'hEC10, 1'b0, 1'b0, 12'h000}, // R6 arm
        {16'hFABC, 1'b0, 1'b0, 16'hFABC, 1'b0, 1'b1, 12'hABC}, // R6
        {16'h2400, 1'b0, 1'b0, 16'h2400, 1'b0, 1'b0, 12'h000}, // R3
        {16'hED01, 1'b0, 1'b0, 16'hED01, 1'b0, 1'b0, 12'h000}, // R10 arm
        {16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000}, // R10 normal
        {16'hF777, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 12'h000}, // R10 dropped
        {16'hEF55, 1'b0, 1'b0, 16'hEF55, 1'b0, 1'b0, 12'h000}, // R8 arm
        {16'hF999, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 12'h000}  // R5 R8 both
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fetch_word = '0; branch_taken = 1'b0; skip_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset ir", ir, 16'h0000);
        check("R9 reset nop", forced_nop, 1);
        check("R9 reset litv", lit_valid, 0);
        check("R1 reset phase", q_phase, 4'b0001);
        rst = 1'b0;
        @(negedge clk); // Q2 of first instruction cycle
        check("R9 first cycle nop", forced_nop, 1);
        check("R1 phase Q2", q_phase, 4'b0010);
        check("R4 no read on nop", rd_strobe, 0);
        @(negedge clk);
        check("R1 phase Q3", q_phase, 4'b0100);
        @(negedge clk); // Q4
        check("R1 phase Q4", q_phase, 4'b1000);
        check("R2 no pc_inc in Q4", pc_inc, 0);

        for (int k = 0; k < NV; k++) begin
            logic [15:0] w, e_ir;
            logic        br, sk, e_nop, e_lv;
            logic [11:0] e_lit;
            {w, br, sk, e_ir, e_nop, e_lv, e_lit} = VEC[k];
            fetch_word = w; branch_taken = br; skip_req = sk;
            @(negedge clk); // Q1
            fetch_word = 16'hDEAD; branch_taken = 1'b0; skip_req = 1'b0;
            check("R1 Q1", q_phase, 4'b0001);
            check("R2 pc_inc Q1", pc_inc, 1);
            @(negedge clk); // Q2
            check("R3 ir", ir, e_ir);
            check("R5 R7 R8 forced_nop", forced_nop, e_nop);
            check("R6 lit_valid", lit_valid, e_lv);
            if (e_lv) check("R6 lit_data", lit_data, e_lit);
            check("R4 rd_strobe", rd_strobe, !e_nop);
            check("R2 no pc_inc Q2", pc_inc, 0);
            @(negedge clk); // Q3
            check("R4 no wr in Q3", wr_strobe, 0);
            @(negedge clk); // Q4
            check("R4 wr_strobe", wr_strobe, !e_nop);
            check("R3 ir held", ir, e_ir);
            check("R6 lit_valid held", lit_valid, e_lv);
        end

        // R9: synchronous reset mid-stream restores the empty-pipeline state
        fetch_word = 16'h3333;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset again ir", ir, 16'h0000);
        check("R9 reset again nop", forced_nop, 1);
        check("R1 reset again phase", q_phase, 4'b0001);
        rst = 1'b0;
        @(negedge clk);
        check("R9 post-reset nop", forced_nop, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule